// File: doc/BRIEF.md
# Receive Buffer Read Lock Controller

This block keeps CPU reads of a receive message buffer consistent while the receiver goes on storing frames. Each buffer appears to the CPU as a small group of words: a control/status word, an ID word, one or more data words and a timestamp word. The block decodes the CPU read and write strobes against that address map. It holds a single buffer lock and publishes it to the matching logic. It keeps one serviced bit per buffer. It gates the receiver's store requests and raises a BUSY indication while a store into the addressed buffer is in progress.

A CPU service sequence works like this. A control/status read takes the lock. ID and data reads follow. A timestamp read then releases the lock and marks the buffer as serviced. If the CPU skips the timestamp read, the lock stays where it is until a control/status read of some other buffer moves it. A CPU write to a control/status word sends a one-cycle drop pulse for that buffer, so the matching logic removes it from any evaluation in progress. All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `rxbuf_lock_ctrl`

## Requirements
- R1: The word address is {buffer index, word offset}. Offset 0 is control/status, offset 1 is ID, offset WORDS_PER_BUF-1 is the timestamp, and the offsets in between are data. A control/status read while `busy_flag` is low sets `lock_valid` and loads `lock_idx` with the addressed buffer on the next cycle.
- R2: A timestamp read of the locked buffer clears `lock_valid` and sets that buffer's `serviced` bit on the next cycle.
- R3: A control/status read of a different buffer moves the lock to that buffer and leaves the old buffer's `serviced` bit unchanged. A repeat read of the locked buffer's control/status word keeps the lock in place.
- R4: ID reads, data reads and timestamp reads of an unlocked buffer leave `lock_valid`, `lock_idx` and `serviced` unchanged.
- R5: `busy_flag` is high in any cycle where the receiver was granted a store into buffer X in the previous cycle, is still active on X, and the CPU addresses buffer X. A control/status read while `busy_flag` is high does not change the lock.
- R6: `rx_wr_grant` is low whenever `rx_wr_active` targets the locked buffer.
- R7: If a control/status read that takes the lock and a receiver request target the same buffer in the same cycle, the lock is taken and `rx_wr_grant` is low.
- R8: A granted receiver store clears the target buffer's `serviced` bit on the next cycle.
- R9: A CPU write to a control/status word raises only that buffer's bit of `match_drop` for exactly one cycle, on the next cycle. It does not change the lock.
- R10: Reset clears `lock_valid`, every `serviced` bit and `match_drop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU word address {buffer index, word offset} |
| cpu_rd | input | 1 | CPU read strobe, one access per cycle |
| cpu_wr | input | 1 | CPU write strobe |
| rx_wr_active | input | 1 | Receiver requests or continues a store |
| rx_wr_idx | input | IDX_W | Buffer targeted by the receiver |
| lock_valid | output | 1 | A buffer is locked |
| lock_idx | output | IDX_W | Locked buffer index |
| serviced | output | NUM_BUF | Per-buffer serviced bits |
| busy_flag | output | 1 | BUSY bit for the code field of the addressed buffer |
| rx_wr_grant | output | 1 | Receiver store allowed this cycle |
| match_drop | output | NUM_BUF | One-cycle per-buffer pulse: leave the match in progress |

## Verification
The properties assume that `cpu_rd` and `cpu_wr` are never high in the same cycle, and that every buffer index fits the power-of-two buffer count. They also assume that a receiver store which has been granted is requested until it ends. The bench drives one access per clock at the falling edge and never raises both strobes together. It keeps `rx_wr_active` on the same index for the length of each store, so the BUSY and grant outcomes match a reference model built only from the requirements.

// File: rtl/rxl_pkg.sv
`timescale 1ns/1ps
package rxl_pkg;

  typedef enum logic [1:0] {
    WK_CTRL  = 2'd0,
    WK_ID    = 2'd1,
    WK_DATA  = 2'd2,
    WK_STAMP = 2'd3
  } word_kind_e;

  // Classify a word offset within one buffer.
  function automatic word_kind_e kind_of(input int unsigned ofs, input int unsigned words);
    if (ofs == 0)               return WK_CTRL;
    else if (ofs == 1)          return WK_ID;
    else if (ofs == words - 1)  return WK_STAMP;
    else                        return WK_DATA;
  endfunction

endpackage

// File: rtl/rxl_addr_decode.sv
`timescale 1ns/1ps
module rxl_addr_decode #(
  parameter int NUM_BUF       = 16,
  parameter int WORDS_PER_BUF = 4,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int OFS_W  = $clog2(WORDS_PER_BUF),
  localparam int ADDR_W = IDX_W + OFS_W
) (
  input  logic [ADDR_W-1:0]       cpu_addr,
  output logic [IDX_W-1:0]        buf_idx,
  output rxl_pkg::word_kind_e     kind
);
  logic [OFS_W-1:0] ofs;

  assign buf_idx = cpu_addr[ADDR_W-1:OFS_W];
  assign ofs     = cpu_addr[OFS_W-1:0];

  always_comb begin
    kind = rxl_pkg::kind_of(int'(ofs), WORDS_PER_BUF);
  end
endmodule

// File: rtl/rxl_lock_track.sv
`timescale 1ns/1ps
module rxl_lock_track #(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             rd_stamp,
  input  logic [IDX_W-1:0] cpu_buf,
  output logic             lock_valid,
  output logic [IDX_W-1:0] lock_idx,
  output logic             release_hit
);
  // Timestamp read only frees the lock when it targets the locked buffer.
  assign release_hit = rd_stamp && lock_valid && (cpu_buf == lock_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_valid <= 1'b0;
      lock_idx   <= '0;
    end else if (take) begin
      lock_valid <= 1'b1;
      lock_idx   <= take_idx;
    end else if (release_hit) begin
      lock_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rxl_rx_arbiter.sv
`timescale 1ns/1ps
module rxl_rx_arbiter #(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_wr_active,
  input  logic [IDX_W-1:0] rx_wr_idx,
  input  logic             lock_valid,
  input  logic [IDX_W-1:0] lock_idx,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic [IDX_W-1:0] cpu_buf,
  output logic             rx_wr_grant,
  output logic             busy_flag
);
  logic             ong_q;
  logic [IDX_W-1:0] ong_idx_q;
  logic             hits_lock;
  logic             hits_take;

  // A store already under way keeps its buffer reported as BUSY.
  assign busy_flag = ong_q && rx_wr_active && (rx_wr_idx == ong_idx_q)
                     && (cpu_buf == ong_idx_q);

  assign hits_lock   = lock_valid && (lock_idx == rx_wr_idx);
  assign hits_take   = take && (take_idx == rx_wr_idx);
  assign rx_wr_grant = rx_wr_active && !hits_lock && !hits_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ong_q     <= 1'b0;
      ong_idx_q <= '0;
    end else begin
      ong_q     <= rx_wr_grant;
      ong_idx_q <= rx_wr_idx;
    end
  end
endmodule

// File: rtl/rxl_buf_flags.sv
`timescale 1ns/1ps
module rxl_buf_flags #(
  parameter int NUM_BUF = 16,
  localparam int IDX_W = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               release_hit,
  input  logic [IDX_W-1:0]   lock_idx,
  input  logic               rx_wr_grant,
  input  logic [IDX_W-1:0]   rx_wr_idx,
  input  logic               wr_ctrl,
  input  logic [IDX_W-1:0]   cpu_buf,
  output logic [NUM_BUF-1:0] serviced,
  output logic [NUM_BUF-1:0] match_drop
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic set_svc;
    logic clr_svc;
    assign set_svc = release_hit && (lock_idx == IDX_W'(i));
    assign clr_svc = rx_wr_grant && (rx_wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        serviced[i]   <= 1'b0;
        match_drop[i] <= 1'b0;
      end else begin
        if (clr_svc)      serviced[i] <= 1'b0;
        else if (set_svc) serviced[i] <= 1'b1;
        match_drop[i] <= wr_ctrl && (cpu_buf == IDX_W'(i));
      end
    end
  end
endmodule

// File: rtl/rxbuf_lock_ctrl.sv
`timescale 1ns/1ps
module rxbuf_lock_ctrl #(
  parameter int NUM_BUF       = 16,
  parameter int WORDS_PER_BUF = 4,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int OFS_W  = $clog2(WORDS_PER_BUF),
  localparam int ADDR_W = IDX_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic               rx_wr_active,
  input  logic [IDX_W-1:0]   rx_wr_idx,
  output logic               lock_valid,
  output logic [IDX_W-1:0]   lock_idx,
  output logic [NUM_BUF-1:0] serviced,
  output logic               busy_flag,
  output logic               rx_wr_grant,
  output logic [NUM_BUF-1:0] match_drop
);
  logic [IDX_W-1:0]    cpu_buf;
  rxl_pkg::word_kind_e kind;
  logic                take;
  logic                rd_stamp;
  logic                wr_ctrl;
  logic                release_hit;

  rxl_addr_decode #(.NUM_BUF(NUM_BUF), .WORDS_PER_BUF(WORDS_PER_BUF)) u_dec (
    .cpu_addr (cpu_addr),
    .buf_idx  (cpu_buf),
    .kind     (kind)
  );

  assign take     = cpu_rd && (kind == rxl_pkg::WK_CTRL) && !busy_flag;
  assign rd_stamp = cpu_rd && (kind == rxl_pkg::WK_STAMP);
  assign wr_ctrl  = cpu_wr && (kind == rxl_pkg::WK_CTRL);

  rxl_rx_arbiter #(.NUM_BUF(NUM_BUF)) u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_wr_active (rx_wr_active),
    .rx_wr_idx    (rx_wr_idx),
    .lock_valid   (lock_valid),
    .lock_idx     (lock_idx),
    .take         (take),
    .take_idx     (cpu_buf),
    .cpu_buf      (cpu_buf),
    .rx_wr_grant  (rx_wr_grant),
    .busy_flag    (busy_flag)
  );

  rxl_lock_track #(.NUM_BUF(NUM_BUF)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .take_idx    (cpu_buf),
    .rd_stamp    (rd_stamp),
    .cpu_buf     (cpu_buf),
    .lock_valid  (lock_valid),
    .lock_idx    (lock_idx),
    .release_hit (release_hit)
  );

  rxl_buf_flags #(.NUM_BUF(NUM_BUF)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .release_hit (release_hit),
    .lock_idx    (lock_idx),
    .rx_wr_grant (rx_wr_grant),
    .rx_wr_idx   (rx_wr_idx),
    .wr_ctrl     (wr_ctrl),
    .cpu_buf     (cpu_buf),
    .serviced    (serviced),
    .match_drop  (match_drop)
  );
endmodule

// File: rtl/rxbuf_lock_ctrl_chk.sv
`timescale 1ns/1ps
module rxbuf_lock_ctrl_chk #(
  parameter int NUM_BUF       = 16,
  parameter int WORDS_PER_BUF = 4,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int OFS_W  = $clog2(WORDS_PER_BUF),
  localparam int ADDR_W = IDX_W + OFS_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic               rx_wr_active,
  input logic [IDX_W-1:0]   rx_wr_idx,
  input logic               lock_valid,
  input logic [IDX_W-1:0]   lock_idx,
  input logic [NUM_BUF-1:0] serviced,
  input logic               busy_flag,
  input logic               rx_wr_grant,
  input logic [NUM_BUF-1:0] match_drop
);
  logic [IDX_W-1:0]    c_buf;
  rxl_pkg::word_kind_e c_kind;
  logic [IDX_W-1:0]    q_cbuf;
  logic [IDX_W-1:0]    q_ridx;
  logic [IDX_W-1:0]    q_lidx;
  logic                q_svc_old;

  assign c_buf = cpu_addr[ADDR_W-1:OFS_W];
  always_comb c_kind = rxl_pkg::kind_of(int'(cpu_addr[OFS_W-1:0]), WORDS_PER_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cbuf <= '0; q_ridx <= '0; q_lidx <= '0; q_svc_old <= 1'b0;
    end else begin
      q_cbuf    <= c_buf;
      q_ridx    <= rx_wr_idx;
      q_lidx    <= lock_idx;
      q_svc_old <= serviced[lock_idx];
    end
  end

  p_lock_on_ctrl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && c_kind == rxl_pkg::WK_CTRL && !busy_flag) |=> (lock_valid && lock_idx == q_cbuf));

  p_stamp_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && c_kind == rxl_pkg::WK_STAMP && lock_valid && c_buf == lock_idx)
      |=> (!lock_valid && serviced[q_cbuf]));

  p_move_keeps_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && c_kind == rxl_pkg::WK_CTRL && !busy_flag && lock_valid && c_buf != lock_idx)
      |=> (serviced[q_lidx] == q_svc_old));

  p_idle_words_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (c_kind == rxl_pkg::WK_ID || c_kind == rxl_pkg::WK_DATA))
      |=> ($stable(lock_valid) && $stable(lock_idx)));

  p_busy_holds_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && c_kind == rxl_pkg::WK_CTRL && busy_flag)
      |=> ($stable(lock_valid) && $stable(lock_idx)));

  p_locked_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_valid && rx_wr_active && rx_wr_idx == lock_idx) |-> !rx_wr_grant);

  p_lock_beats_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && c_kind == rxl_pkg::WK_CTRL && !busy_flag && rx_wr_active && c_buf == rx_wr_idx)
      |-> !rx_wr_grant);

  p_grant_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_grant |=> !serviced[q_ridx]);

  p_drop_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_drop));

  p_drop_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && c_kind == rxl_pkg::WK_CTRL) |=> match_drop[q_cbuf]);
endmodule

bind rxbuf_lock_ctrl rxbuf_lock_ctrl_chk #(
  .NUM_BUF(NUM_BUF), .WORDS_PER_BUF(WORDS_PER_BUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .rx_wr_active(rx_wr_active), .rx_wr_idx(rx_wr_idx), .lock_valid(lock_valid),
  .lock_idx(lock_idx), .serviced(serviced), .busy_flag(busy_flag),
  .rx_wr_grant(rx_wr_grant), .match_drop(match_drop)
);

// File: tb/rxbuf_lock_ctrl_bench.sv
`timescale 1ns/1ps
module rxbuf_lock_ctrl_bench;
  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        rx_wr_active = 1'b0;
  logic [3:0]  rx_wr_idx = '0;
  logic        lock_valid;
  logic [3:0]  lock_idx;
  logic [NB-1:0] serviced;
  logic        busy_flag;
  logic        rx_wr_grant;
  logic [NB-1:0] match_drop;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rxbuf_lock_ctrl u_rxbuf_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .rx_wr_active(rx_wr_active), .rx_wr_idx(rx_wr_idx), .lock_valid(lock_valid),
    .lock_idx(lock_idx), .serviced(serviced), .busy_flag(busy_flag),
    .rx_wr_grant(rx_wr_grant), .match_drop(match_drop)
  );

  typedef struct {
    string     tag;
    bit        lv;
    bit [3:0]  li;
    bit [NB-1:0] svc;
    bit [NB-1:0] drop;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  bit        m_lv = 0;
  bit [3:0]  m_li = 0;
  bit [NB-1:0] m_svc = 0;
  bit        m_ong = 0;
  bit [3:0]  m_ongi = 0;

  task automatic chk(string tag, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare registered outputs away from the rising edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "lock_valid", lock_valid, e.lv);
      if (e.lv) chk(e.tag, "lock_idx", lock_idx, e.li);
      chk(e.tag, "serviced", serviced, e.svc);
      chk(e.tag, "match_drop", match_drop, e.drop);
    end
  end

  // word offsets: 0 ctrl, 1 id, 2 data, 3 timestamp
  task automatic op(bit rd, bit wr, int b, int w, bit rxa, int rxi, string tag);
    bit busy, take, grant;
    exp_t e;
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr;
    cpu_addr = 6'(b * 4 + w);
    rx_wr_active = rxa; rx_wr_idx = 4'(rxi);
    #2;
    busy  = m_ong && rxa && (4'(rxi) == m_ongi) && (4'(b) == m_ongi);
    take  = rd && (w == 0) && !busy;
    grant = rxa && !(m_lv && m_li == 4'(rxi)) && !(take && 4'(b) == 4'(rxi));
    chk("R5", "busy_flag", busy_flag, busy);
    chk((take && rxa) ? "R7" : "R6", "rx_wr_grant", rx_wr_grant, grant);
    if (take) begin
      m_lv = 1; m_li = 4'(b);
    end else if (rd && w == 3 && m_lv && m_li == 4'(b)) begin
      m_lv = 0; m_svc[b] = 1'b1;
    end
    if (grant) m_svc[rxi] = 1'b0;
    m_ong = grant; m_ongi = 4'(rxi);
    e.tag = tag; e.lv = m_lv; e.li = m_li; e.svc = m_svc;
    e.drop = (wr && w == 0) ? (NB'(1) << b) : '0;
    exp_q.push_back(e);
  endtask

  task automatic idle(string tag);
    op(0, 0, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle("R10");                          // reset state
    op(1, 0, 3, 0, 0, 0, "R1");           // lock buffer 3
    op(1, 0, 3, 1, 0, 0, "R4");           // id read
    op(1, 0, 3, 2, 0, 0, "R4");           // data read
    op(1, 0, 5, 3, 0, 0, "R4");           // timestamp of unlocked buffer
    op(1, 0, 3, 3, 0, 0, "R2");           // release, serviced[3]
    op(1, 0, 7, 0, 0, 0, "R1");
    op(1, 0, 7, 0, 0, 0, "R3");           // re-read keeps lock
    op(1, 0, 9, 0, 0, 0, "R3");           // move, 7 not serviced
    op(0, 0, 0, 1, 1, 9, "R6");           // rx on locked buffer
    op(0, 0, 0, 1, 1, 3, "R8");           // clears serviced[3]
    op(1, 0, 4, 0, 1, 4, "R7");           // same-cycle lock vs rx
    op(1, 0, 4, 3, 0, 0, "R2");
    op(0, 0, 6, 1, 1, 6, "R5");           // store into 6 starts
    op(1, 0, 6, 0, 1, 6, "R5");           // busy, ctrl read ignored
    op(1, 0, 6, 2, 1, 6, "R5");
    op(1, 0, 6, 0, 0, 0, "R1");           // store ended, lock 6
    op(0, 1, 10, 0, 0, 0, "R9");          // ctrl write -> drop pulse
    idle("R9");                           // pulse gone
    op(0, 1, 11, 2, 0, 0, "R9");          // data write: no drop
    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(0, 4);
      int b    = $urandom_range(0, 3);
      int w    = $urandom_range(0, 3);
      bit rxa  = ($urandom_range(0, 2) == 0);
      int rxi  = $urandom_range(0, 3);
      string t = (w == 0) ? "R1" : (w == 3) ? "R2" : "R4";
      if (kind == 4) op(0, 1, b, w, rxa, rxi, "R9");
      else           op(1, 0, b, w, rxa, rxi, t);
    end
    idle("R8");
    idle("R8");
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule